// File: doc/BRIEF.md
# Way-Record Back-Pointer Tracker

This block keeps a table of base-register way records coherent with a set-associative L1 data cache, without searching the records. Each cache line owns a small bit vector with one bit per integer base register. When a normal-mode cache access builds a way record for a register, the bit for that register is set in the accessed line's vector. When the cache evicts or invalidates a line, the tracker reads that line's vector and, on the next clock, sends it to the record table as a kill mask. In the same cycle it cancels any direct, tag-less access that sits in the execute/memory pipeline latch and targets the dying line.

A global flush input handles events that can make every record stale, such as a context switch, a change to the memory map or access permissions, or a replacement in the data TLB. A flush kills all records, cancels any valid in-flight direct access, and empties every line vector in one cycle. A fill input empties the vector of a line that has just received a new block. Stale bits left behind when a record is rebuilt elsewhere are kept on purpose. At worst they cause one extra kill, which is harmless.

Top module: `way_backptr_tracker`

## Requirements
- R1: After synchronous reset, `kill_mask_o` and `inflight_cancel_o` are 0, and every line vector is empty. An eviction of any line then yields a kill mask of 0.
- R2: A build (`bld_valid_i` with `bld_line_i`, `bld_reg_i`) sets bit `bld_reg_i` in that line's vector, and builds for several registers on the same line accumulate. One cycle after an eviction of the line, `kill_mask_o` equals the vector, with bit n standing for base register n.
- R3: An eviction empties the evicted line's vector, so a second eviction of the same line yields a kill mask of 0.
- R4: A fill (`fill_valid_i`, `fill_line_i`) empties that line's vector, so a later eviction of it yields a kill mask of 0.
- R5: One cycle after `flush_i`, `kill_mask_o` is all ones. Every line vector is then empty, and a build presented in the flush cycle is dropped.
- R6: If an eviction and a build name the same line in the same cycle, the eviction wins. The build's register bit is added to that eviction's kill mask and is not stored, so a following eviction of the line yields 0.
- R7: One cycle after an eviction, `inflight_cancel_o` is 1 exactly when `inflight_valid_i` was 1 and `inflight_line_i` equalled the evicted line. An in-flight access with no eviction and no flush is never cancelled.
- R8: One cycle after `flush_i`, `inflight_cancel_o` equals the `inflight_valid_i` of the flush cycle, whatever its line.
- R9: Rebuilding a register's record on another line does not clear its bit in the line it used before. Evicting the old line still reports that register.
- R10: In any cycle after one with neither an eviction nor a flush, both outputs are 0.
- R11: A fill and a build on the same line in the same cycle leave that line's vector holding only the new build's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bld_valid_i | input | 1 | A normal-mode access built a way record |
| bld_line_i | input | LINE_W | Cache line index the record points to |
| bld_reg_i | input | REG_W | Base register id of the record |
| evict_valid_i | input | 1 | A cache line is evicted or invalidated |
| evict_line_i | input | LINE_W | Index of the line leaving the cache |
| fill_valid_i | input | 1 | A new block is written into a line |
| fill_line_i | input | LINE_W | Index of the filled line |
| flush_i | input | 1 | Global stale event: kill all records |
| inflight_valid_i | input | 1 | Execute/memory latch holds a direct access |
| inflight_line_i | input | LINE_W | Line targeted by that direct access |
| kill_mask_o | output | NUM_REGS | Registered mask of records to invalidate |
| inflight_cancel_o | output | 1 | Registered cancel for the latched direct access |

## Verification
The bench targets the same-cycle collisions: an eviction against a build on one line, a fill against a build on one line, and a flush against a build or an in-flight access. A design that let the build win the eviction race would leave a record pointing at a dead line, and the bench would see the bit missing from the kill mask and reappearing on a later eviction. A design that cleared the vector on the wrong event, or left it full after an eviction, fill or flush, would report bits on a second eviction. A design that compared the in-flight line loosely would cancel accesses to unrelated lines, or miss the matching one. The bench also evicts the highest line index, and it checks that a stale bit survives a rebuild of its record on another line.

// File: rtl/tcbp_pkg.sv
package tcbp_pkg;
  localparam int unsigned TCBP_LINES = 512;
  localparam int unsigned TCBP_REGS  = 16;
endpackage

// File: rtl/tcbp_vec_store.sv
module tcbp_vec_store #(
  parameter int unsigned NUM_LINES = 512,
  parameter int unsigned NUM_REGS  = 16,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bld_v,
  input  logic [LINE_W-1:0]   bld_line,
  input  logic [REG_W-1:0]    bld_reg,
  input  logic                ev_v,
  input  logic [LINE_W-1:0]   ev_line,
  input  logic                fill_v,
  input  logic [LINE_W-1:0]   fill_line,
  input  logic                flush,
  output logic [NUM_REGS-1:0] ev_vec_o
);
  // Vector storage: one write port, asynchronous reads (distributed RAM)
  logic [NUM_REGS-1:0] vec_mem [NUM_LINES];
  // Per-line "vector meaningful" flags, clearable in one cycle
  logic [NUM_LINES-1:0] line_live;

  logic                collide;
  logic                fill_on_bld;
  logic                do_write;
  logic [NUM_REGS-1:0] bld_base;
  logic [NUM_REGS-1:0] bld_onehot;

  always_comb begin
    collide     = bld_v && ev_v && (bld_line == ev_line);
    fill_on_bld = fill_v && (fill_line == bld_line);
    do_write    = bld_v && !flush && !collide;
    bld_onehot  = NUM_REGS'(1) << bld_reg;
    bld_base    = (line_live[bld_line] && !fill_on_bld) ? vec_mem[bld_line] : '0;
    ev_vec_o    = line_live[ev_line] ? vec_mem[ev_line] : '0;
  end

  always_ff @(posedge clk) begin
    if (do_write) vec_mem[bld_line] <= bld_base | bld_onehot;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      line_live <= '0;
    end else begin
      if (fill_v)   line_live[fill_line] <= 1'b0;
      if (ev_v)     line_live[ev_line]   <= 1'b0;
      if (do_write) line_live[bld_line]  <= 1'b1;
    end
  end

  AST_BUILD_MARKS_LINE: assert property (@(posedge clk) disable iff (rst)
    (bld_v && !flush && !(ev_v && ev_line == bld_line)) |=> line_live[$past(bld_line)]); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (line_live == '0)); // R5
endmodule

// File: rtl/tcbp_kill_gen.sv
module tcbp_kill_gen #(
  parameter int unsigned NUM_LINES = 512,
  parameter int unsigned NUM_REGS  = 16,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_v,
  input  logic [LINE_W-1:0]   ev_line,
  input  logic [NUM_REGS-1:0] ev_vec,
  input  logic                bld_v,
  input  logic [LINE_W-1:0]   bld_line,
  input  logic [REG_W-1:0]    bld_reg,
  input  logic                flush,
  input  logic                inf_v,
  input  logic [LINE_W-1:0]   inf_line,
  output logic [NUM_REGS-1:0] kill_mask_o,
  output logic                cancel_o
);
  logic [NUM_REGS-1:0] late_bit;

  always_comb begin
    late_bit = (bld_v && bld_line == ev_line) ? (NUM_REGS'(1) << bld_reg) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_mask_o <= '0;
      cancel_o    <= 1'b0;
    end else if (flush) begin
      kill_mask_o <= '1;
      cancel_o    <= inf_v;
    end else if (ev_v) begin
      kill_mask_o <= ev_vec | late_bit;
      cancel_o    <= inf_v && (inf_line == ev_line);
    end else begin
      kill_mask_o <= '0;
      cancel_o    <= 1'b0;
    end
  end

  AST_COLLIDE_KILLS_BUILDER: assert property (@(posedge clk) disable iff (rst)
    (ev_v && bld_v && ev_line == bld_line) |=> kill_mask_o[$past(bld_reg)]); // R6
  AST_CANCEL_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (ev_v && inf_v && ev_line == inf_line) |=> cancel_o); // R7
endmodule

// File: rtl/way_backptr_tracker.sv
module way_backptr_tracker #(
  parameter int unsigned NUM_LINES = tcbp_pkg::TCBP_LINES,
  parameter int unsigned NUM_REGS  = tcbp_pkg::TCBP_REGS,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bld_valid_i,
  input  logic [LINE_W-1:0]   bld_line_i,
  input  logic [REG_W-1:0]    bld_reg_i,
  input  logic                evict_valid_i,
  input  logic [LINE_W-1:0]   evict_line_i,
  input  logic                fill_valid_i,
  input  logic [LINE_W-1:0]   fill_line_i,
  input  logic                flush_i,
  input  logic                inflight_valid_i,
  input  logic [LINE_W-1:0]   inflight_line_i,
  output logic [NUM_REGS-1:0] kill_mask_o,
  output logic                inflight_cancel_o
);
  logic [NUM_REGS-1:0] ev_vec;

  tcbp_vec_store #(.NUM_LINES(NUM_LINES), .NUM_REGS(NUM_REGS)) u_store (
    .clk       (clk),
    .rst       (rst),
    .bld_v     (bld_valid_i),
    .bld_line  (bld_line_i),
    .bld_reg   (bld_reg_i),
    .ev_v      (evict_valid_i),
    .ev_line   (evict_line_i),
    .fill_v    (fill_valid_i),
    .fill_line (fill_line_i),
    .flush     (flush_i),
    .ev_vec_o  (ev_vec)
  );

  tcbp_kill_gen #(.NUM_LINES(NUM_LINES), .NUM_REGS(NUM_REGS)) u_kill (
    .clk         (clk),
    .rst         (rst),
    .ev_v        (evict_valid_i),
    .ev_line     (evict_line_i),
    .ev_vec      (ev_vec),
    .bld_v       (bld_valid_i),
    .bld_line    (bld_line_i),
    .bld_reg     (bld_reg_i),
    .flush       (flush_i),
    .inf_v       (inflight_valid_i),
    .inf_line    (inflight_line_i),
    .kill_mask_o (kill_mask_o),
    .cancel_o    (inflight_cancel_o)
  );

  AST_QUIET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(evict_valid_i) && !$past(flush_i))
      |-> (kill_mask_o == '0 && !inflight_cancel_o)); // R10
  AST_FLUSH_KILLS_ALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush_i)) |-> (kill_mask_o == '1)); // R5
  AST_FLUSH_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flush_i)) |-> (inflight_cancel_o == $past(inflight_valid_i))); // R8
  AST_CANCEL_NEEDS_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && inflight_cancel_o) |-> $past(inflight_valid_i)); // R7
endmodule

// File: tb/way_backptr_tracker_bench.sv
module way_backptr_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 512;
  localparam int NR = 16;
  localparam int LW = $clog2(NL);
  localparam int RW = $clog2(NR);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bld_v = 0, ev_v = 0, fill_v = 0, flush = 0, inf_v = 0;
  logic [LW-1:0] bld_line = '0, ev_line = '0, fill_line = '0, inf_line = '0;
  logic [RW-1:0] bld_reg = '0;
  logic [NR-1:0] kill_mask;
  logic          cancel;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  bit [NR-1:0] model [int];
  bit [NR-1:0] exp_mask;
  bit          exp_cancel;

  always #(CLK_PERIOD/2) clk = ~clk;

  way_backptr_tracker #(.NUM_LINES(NL), .NUM_REGS(NR)) u_way_backptr_tracker (
    .clk(clk), .rst(rst),
    .bld_valid_i(bld_v), .bld_line_i(bld_line), .bld_reg_i(bld_reg),
    .evict_valid_i(ev_v), .evict_line_i(ev_line),
    .fill_valid_i(fill_v), .fill_line_i(fill_line),
    .flush_i(flush),
    .inflight_valid_i(inf_v), .inflight_line_i(inf_line),
    .kill_mask_o(kill_mask), .inflight_cancel_o(cancel)
  );

  function automatic bit [NR-1:0] vec_of(int l);
    return model.exists(l) ? model[l] : '0;
  endfunction

  // Behavioural reference: evaluated from the inputs held across the edge
  task automatic model_step();
    bit [NR-1:0] m;
    exp_mask = '0; exp_cancel = 0;
    if (flush) begin
      exp_mask = '1; exp_cancel = inf_v;
      model.delete();
    end else begin
      if (ev_v) begin
        m = vec_of(int'(ev_line));
        if (bld_v && bld_line == ev_line) m[bld_reg] = 1'b1;
        exp_mask = m;
        exp_cancel = inf_v && (inf_line == ev_line);
      end
      if (fill_v) model.delete(int'(fill_line));
      if (ev_v) model.delete(int'(ev_line));
      if (bld_v && !(ev_v && bld_line == ev_line)) begin
        m = vec_of(int'(bld_line));
        m[bld_reg] = 1'b1;
        model[int'(bld_line)] = m;
      end
    end
  endtask

  task automatic check(string tag);
    n_tests++;
    if (kill_mask !== exp_mask) begin
      n_fail++;
      $display("FAIL %s kill_mask actual=%h expected=%h", tag, kill_mask, exp_mask);
    end
    n_tests++;
    if (cancel !== exp_cancel) begin
      n_fail++;
      $display("FAIL %s cancel actual=%0b expected=%0b", tag, cancel, exp_cancel);
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
    bld_v = 0; ev_v = 0; fill_v = 0; flush = 0; inf_v = 0;
  endtask

  task automatic build(int l, int r, string tag);
    bld_v = 1; bld_line = LW'(l); bld_reg = RW'(r); cyc(tag);
  endtask

  task automatic evict(int l, string tag);
    ev_v = 1; ev_line = LW'(l); cyc(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    exp_mask = '0; exp_cancel = 0;
    check("R1 reset");
    evict(5, "R1 empty after reset");
    // R2 accumulation, R10 quiet cycles
    build(10, 3, "R10"); build(10, 7, "R10"); build(20, 0, "R10");
    evict(10, "R2 accumulated vector");
    cyc("R10 idle");
    evict(10, "R3 second eviction");
    evict(20, "R2 single bit");
    // R4 fill clears
    build(30, 1, "R10"); fill_v = 1; fill_line = LW'(30); cyc("R4 fill");
    evict(30, "R4 after fill");
    // R5/R8 flush
    build(40, 2, "R10"); build(41, 4, "R10");
    flush = 1; inf_v = 1; inf_line = LW'(99); bld_v = 1; bld_line = LW'(42); bld_reg = RW'(8);
    cyc("R5 R8 flush");
    evict(40, "R5 cleared 40"); evict(41, "R5 cleared 41"); evict(42, "R5 build dropped");
    flush = 1; cyc("R8 flush no inflight");
    // R6 collision
    build(50, 5, "R10");
    ev_v = 1; ev_line = LW'(50); bld_v = 1; bld_line = LW'(50); bld_reg = RW'(9);
    cyc("R6 collide");
    evict(50, "R6 not stored");
    // R7 in-flight
    build(60, 6, "R10");
    ev_v = 1; ev_line = LW'(60); inf_v = 1; inf_line = LW'(60); cyc("R7 match");
    build(61, 6, "R10");
    ev_v = 1; ev_line = LW'(61); inf_v = 1; inf_line = LW'(62); cyc("R7 mismatch");
    inf_v = 1; inf_line = LW'(63); cyc("R7 no event");
    // R9 stale bit
    build(70, 11, "R10"); build(71, 11, "R10");
    evict(70, "R9 stale old line"); evict(71, "R9 new line");
    // R11 fill + build same cycle
    build(80, 12, "R10");
    fill_v = 1; fill_line = LW'(80); bld_v = 1; bld_line = LW'(80); bld_reg = RW'(13);
    cyc("R11 fill and build");
    evict(80, "R11 only new bit");
    // boundary line and register
    build(NL-1, NR-1, "R10"); evict(NL-1, "R2 top line");
    for (int i = 0; i < 4; i++) cyc("R10 tail");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule